// File: doc/BRIEF.md
# Reloading Down-Counter Timer Channel

This block is one channel of a periodic timer. A 32-bit counter steps down by one on every prescaled tick while an outside enable input is high. When a tick finds the counter already at zero, the counter takes a fresh value from a separate reload register and a sticky underflow flag is set. The flag, gated by an interrupt-enable bit, drives the channel's interrupt line. Software clears the flag by writing the control register.

Four word-indexed registers are reached through a plain write strobe, a 2-bit word index and a read-data bus that returns the selected register in the same cycle. The registers are the reload constant, the live count, a 16-bit control word and a capture word. The control word selects one of five prescale ratios from the peripheral clock. It also holds the interrupt enable and several mode fields that only hold their values. The capture word is plain storage. The enable input comes from a start register that lives outside the block.

Top module: `tmr_chan`

## Requirements
- R1: After a synchronous reset, the reload constant and the count both read 0xFFFFFFFF, while the control word, the capture word and `irq` are all 0.
- R2: `reg_addr` is a word index that selects a register: 0 is the reload constant (byte offset 0x0), 1 is the count (0x4), 2 is the control word (0x8) and 3 is the capture word (0xC). `reg_rdata` shows the selected register combinationally.
- R3: Control bits [2:0] choose the tick rate. Values 0, 1, 2, 3 and 4 give one tick every 4, 16, 64, 256 and 1024 clocks. A free-running 10-bit prescale count starts at 0 at reset and increments on every clock. A tick occurs in a cycle whose prescale count has its low 2·(sel+1) bits all set. Values 5 to 7 produce no ticks.
- R4: The count drops by one on each tick while `cnt_en` is high. While `cnt_en` is low the count holds, and counting resumes from the held value when `cnt_en` returns high.
- R5: A tick with `cnt_en` high and a count of 0 loads the reload constant into the count and sets the underflow flag.
- R6: Writing the reload constant leaves the count alone, and writing the control word leaves the count alone. Writing the count loads it directly. A count write takes precedence over a tick in the same cycle, and no underflow occurs in that cycle.
- R7: The underflow flag is sticky. A control write with bit 8 = 0 clears it, and a control write with bit 8 = 1 leaves it unchanged. If an underflow happens in the same cycle as a clearing write, the flag ends up set.
- R8: `irq` is high exactly when the underflow flag is set and control bit 5 (interrupt enable) is 1.
- R9: A control read returns the written bits [7:0] and the underflow flag in bit 8. Bits 31 down to 9 read as 0, whatever was written to them.
- R10: The capture word stores any 32-bit value written to index 3 and returns it on a read. It has no effect on counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Count enable from the outside start register |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| irq | output | 1 | Underflow interrupt |

## Verification
The cases hardest to reach from the ports are the ones where a register write lands in the same clock as a prescaled tick. These are a count write that must override a decrement or a reload, and a flag-clearing control write that must lose to a simultaneous underflow. The stimulus reaches them with back-to-back count writes at the fastest prescale setting and with repeated clearing writes while short reload periods keep underflows coming. A behavioural model tracks the prescale phase, so every such overlap is scored on the clock where it happens.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int DATA_W   = 32;
    localparam int CTL_W    = 16;
    localparam int ADDR_W   = 2;
    localparam int PRE_OPTS = 5;
    localparam int PRE_W    = 2 * PRE_OPTS;
    localparam int SEL_W    = 3;
    localparam int UF_BIT   = 8;
    localparam int IE_BIT   = 5;
    localparam int FLD_W    = 8;

    typedef enum logic [ADDR_W-1:0] {
        IDX_CONST = 2'd0,
        IDX_COUNT = 2'd1,
        IDX_CTRL  = 2'd2,
        IDX_CAPT  = 2'd3
    } reg_idx_e;

    // Stored control fields, laid out to match bits [7:0] of the control word
    typedef struct packed {
        logic [1:0]       capt_mode;
        logic             uf_ie;
        logic [1:0]       edge_sel;
        logic [SEL_W-1:0] rate_sel;
    } ctl_fields_t;

    function automatic logic [DATA_W-1:0] ctl_image(ctl_fields_t f, logic flag);
        logic [DATA_W-1:0] img;
        img = '0;
        img[FLD_W-1:0] = f;
        img[UF_BIT]    = flag;
        return img;
    endfunction

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale
    import tmr_pkg::*;
#(
    parameter int OPTS = PRE_OPTS,
    parameter int CW   = 2 * OPTS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    logic [CW-1:0]   pcnt;
    logic [OPTS-1:0] hit;

    always_ff @(posedge clk) begin
        if (rst) pcnt <= '0;
        else     pcnt <= pcnt + 1'b1;
    end

    // Ratio k fires when the low 2*(k+1) bits of the phase are all ones
    generate
        for (genvar k = 0; k < OPTS; k++) begin : g_ratio
            assign hit[k] = &pcnt[2*k+1:0];
        end
    endgenerate

    always_comb begin
        tick = 1'b0;
        for (int k = 0; k < OPTS; k++) begin
            if (sel == SEL_W'(k)) tick = hit[k];
        end
    end

    AST_HOLD_SEL: assert property (@(posedge clk) disable iff (rst)
        (sel >= SEL_W'(OPTS)) |-> !tick); // R3
    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> pcnt == $past(pcnt) + 1'b1); // R3

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
    import tmr_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         en,
    input  logic         ld_count,
    input  logic         ld_const,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] count,
    output logic [W-1:0] reload,
    output logic         uf
);
    logic step;
    logic at_zero;

    assign step    = tick && en && !ld_count;
    assign at_zero = (count == '0);
    assign uf      = step && at_zero;

    always_ff @(posedge clk) begin
        if (rst)           reload <= '1;
        else if (ld_const) reload <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)           count <= '1;
        else if (ld_count) count <= wdata;
        else if (uf)       count <= reload;
        else if (step)     count <= count - 1'b1;
    end

    AST_RELOAD: assert property (@(posedge clk) disable iff (rst)
        uf |=> count == $past(reload)); // R5
    AST_DECR: assert property (@(posedge clk) disable iff (rst)
        (tick && en && !ld_count && count != '0) |=> count == $past(count) - 1'b1); // R4
    AST_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (!en && !ld_count) |=> $stable(count)); // R4
    AST_CONST_ONLY: assert property (@(posedge clk) disable iff (rst)
        (ld_const && !ld_count && !(tick && en)) |=> $stable(count)); // R6
    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
        ld_count |=> count == $past(wdata)); // R6

endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_ctl,
    input  logic [CTL_W-1:0] wdata,
    input  logic             uf,
    output ctl_fields_t      fields,
    output logic             flag
);
    always_ff @(posedge clk) begin
        if (rst)         fields <= '0;
        else if (wr_ctl) fields <= ctl_fields_t'(wdata[FLD_W-1:0]);
    end

    // An underflow in the same cycle outranks a clearing write
    always_ff @(posedge clk) begin
        if (rst)                          flag <= 1'b0;
        else if (uf)                      flag <= 1'b1;
        else if (wr_ctl && !wdata[UF_BIT]) flag <= 1'b0;
    end

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
        uf |=> flag); // R5
    AST_FLAG_KEEP: assert property (@(posedge clk) disable iff (rst)
        (wr_ctl && wdata[UF_BIT] && !uf) |=> flag == $past(flag)); // R7
    AST_FLAG_CLR: assert property (@(posedge clk) disable iff (rst)
        (wr_ctl && !wdata[UF_BIT] && !uf) |=> !flag); // R7
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flag && !wr_ctl) |=> flag); // R7

endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cnt_en,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);
    reg_idx_e          idx;
    logic              wr_const, wr_count, wr_ctl, wr_capt;
    logic              tick, uf, flag;
    logic [DATA_W-1:0] count, reload, capt;
    ctl_fields_t       fields;

    assign idx      = reg_idx_e'(reg_addr);
    assign wr_const = reg_wr && (idx == IDX_CONST);
    assign wr_count = reg_wr && (idx == IDX_COUNT);
    assign wr_ctl   = reg_wr && (idx == IDX_CTRL);
    assign wr_capt  = reg_wr && (idx == IDX_CAPT);

    tmr_prescale #(.OPTS(PRE_OPTS), .CW(PRE_W)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .sel  (fields.rate_sel),
        .tick (tick)
    );

    tmr_counter #(.W(DATA_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .en       (cnt_en),
        .ld_count (wr_count),
        .ld_const (wr_const),
        .wdata    (reg_wdata),
        .count    (count),
        .reload   (reload),
        .uf       (uf)
    );

    tmr_ctrl u_ctl (
        .clk    (clk),
        .rst    (rst),
        .wr_ctl (wr_ctl),
        .wdata  (reg_wdata[CTL_W-1:0]),
        .uf     (uf),
        .fields (fields),
        .flag   (flag)
    );

    always_ff @(posedge clk) begin
        if (rst)          capt <= '0;
        else if (wr_capt) capt <= reg_wdata;
    end

    always_comb begin
        unique case (idx)
            IDX_CONST: reg_rdata = reload;
            IDX_COUNT: reg_rdata = count;
            IDX_CTRL:  reg_rdata = ctl_image(fields, flag);
            default:   reg_rdata = capt;
        endcase
    end

    assign irq = flag && fields.uf_ie;

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
        (wr_ctl && !reg_wdata[IE_BIT]) |=> !irq); // R8
    AST_IRQ_ON_UF: assert property (@(posedge clk) disable iff (rst)
        (uf && fields.uf_ie && !wr_ctl) |=> irq); // R8
    AST_CAPT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_capt |=> $stable(capt)); // R10

endmodule

// File: tb/tmr_chan_bench.sv
module tmr_chan_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cnt_en = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd1;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    tmr_chan u_tmr_chan (
        .clk(clk), .rst(rst), .cnt_en(cnt_en), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    // Behavioural reference model
    logic [31:0] m_const, m_cnt, m_capt;
    logic [7:0]  m_fld;
    logic        m_flag;
    int          m_pre;

    always @(posedge clk) begin
        if (rst) begin
            m_const = 32'hFFFF_FFFF; m_cnt = 32'hFFFF_FFFF;
            m_capt = 0; m_fld = 0; m_flag = 0; m_pre = 0;
        end else begin
            int sel, dv;
            bit tk, ufl;
            logic [31:0] old_const;
            sel = int'(m_fld[2:0]);
            tk = 0;
            if (sel < 5) begin
                dv = 4 << (2 * sel);
                tk = ((m_pre % dv) == dv - 1);
            end
            m_pre = (m_pre + 1) % 1024;
            old_const = m_const;
            ufl = 0;
            if (reg_wr && reg_addr == 2'd1) m_cnt = reg_wdata;
            else if (tk && cnt_en) begin
                if (m_cnt == 0) begin m_cnt = old_const; ufl = 1; end
                else m_cnt = m_cnt - 1;
            end
            if (reg_wr && reg_addr == 2'd0) m_const = reg_wdata;
            if (reg_wr && reg_addr == 2'd3) m_capt = reg_wdata;
            if (reg_wr && reg_addr == 2'd2) begin
                m_fld = reg_wdata[7:0];
                if (!reg_wdata[8]) m_flag = 0;
            end
            if (ufl) m_flag = 1;
        end
    end

    function automatic logic [31:0] exp_rd(logic [1:0] a);
        case (a)
            2'd0: return m_const;
            2'd1: return m_cnt;
            2'd2: return {23'b0, m_flag, m_fld};
            default: return m_capt;
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-clock comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            check("R8 irq", {31'b0, irq}, {31'b0, m_flag & m_fld[5]});
            if (reg_addr == 2'd1) check("R4 count", reg_rdata, m_cnt);
        end
    end

    task automatic wr(logic [1:0] a, logic [31:0] d);
        @(negedge clk); #1;
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); #1;
        reg_wr = 0; reg_addr = 2'd1;
    endtask

    task automatic rd(logic [1:0] a, string tag);
        @(negedge clk); #1;
        reg_addr = a;
        #1 check(tag, reg_rdata, exp_rd(a));
        #1 reg_addr = 2'd1;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1;
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        idle(3);
        #1 rst = 0;
        check("R1 irq reset", {31'b0, irq}, 32'd0);
        rd(2'd0, "R1 const reset"); check("R1 const value", exp_rd(2'd0), 32'hFFFF_FFFF);
        rd(2'd1, "R1 count reset");
        rd(2'd2, "R1 ctrl reset");
        rd(2'd3, "R1 capt reset");
        // fast underflow with interrupt enabled
        wr(2'd0, 32'd5);
        rd(2'd0, "R2 const index");
        wr(2'd1, 32'd3);
        wr(2'd2, 32'h120);
        #1 cnt_en = 1;
        idle(40);
        rd(2'd2, "R5 flag set");
        wr(2'd2, 32'h120);
        rd(2'd2, "R7 write one keeps");
        wr(2'd2, 32'h020);
        rd(2'd2, "R7 write zero clears");
        idle(30);
        rd(2'd2, "R7 sticky after underflow");
        // freeze and resume
        @(negedge clk); #1 cnt_en = 0;
        idle(30);
        rd(2'd1, "R4 frozen");
        @(negedge clk); #1 cnt_en = 1;
        idle(12);
        // clear competing with underflows
        for (int i = 0; i < 12; i++) wr(2'd2, 32'h020);
        // other rates
        wr(2'd2, 32'h001); wr(2'd1, 32'd2); idle(200);
        rd(2'd2, "R3 rate 16");
        wr(2'd2, 32'h022); idle(400);
        wr(2'd2, 32'h005); idle(60);
        rd(2'd1, "R3 hold select");
        wr(2'd2, 32'h023); wr(2'd1, 32'd1); idle(1100);
        wr(2'd2, 32'h004); wr(2'd1, 32'd1); idle(2200);
        rd(2'd2, "R3 rate 1024");
        // constant write while running, then count writes against ticks
        wr(2'd2, 32'h020);
        wr(2'd0, 32'h10); idle(3);
        rd(2'd1, "R6 const write keeps count");
        wr(2'd2, 32'h120); idle(3);
        rd(2'd1, "R6 ctrl write keeps count");
        for (int i = 0; i < 8; i++) wr(2'd1, 32'(i));
        idle(20);
        // capture storage and reserved bits
        wr(2'd3, 32'hA5A5_5A5A);
        rd(2'd3, "R10 capture stores");
        rd(2'd1, "R10 count unaffected");
        wr(2'd2, 32'hFFFF_FFFF);
        rd(2'd2, "R9 reserved read zero");
        wr(2'd2, 32'h0000_0000);
        rd(2'd2, "R9 cleared image");
        idle(5);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule